// File: doc/BRIEF.md
# Folded Symmetric FIR Filter Engine

This block is a streaming FIR filter for linear-phase filters of even length N whose coefficients mirror about the centre. Only the first half of the coefficient set is stored. The engine adds the two samples that share a coefficient, then multiplies the 17-bit sum by that coefficient. Each output therefore costs N/2 multiply-accumulate steps instead of N.

The delay line is two circular buffers of N/2 words. The front buffer holds the newest N/2 samples and the rear buffer holds the older N/2. When a sample is accepted, the oldest front word moves into the rear buffer's oldest slot, and the new sample then takes its place in the front buffer. Both write pointers advance modulo N/2, so they never need to be reset between samples.

Samples enter on a valid/ready handshake. While the engine runs its taps, ready is low. One result per sample leaves as a single-cycle valid pulse. The filter length and the coefficient half-set are parameters.

Top module: `sym_fir_engine`

## Requirements
- R1: For every accepted sample, the output equals sat((sum over i < N/2 of h[i]*(x[n-i] + x[n-(N-1)+i])) >>> 15). h[i] is the signed 16-bit field COEFS[16*i +: 16], and x[n] is the sample just accepted. Samples from before reset count as zero.
- R2: The delay line holds exactly N samples as two halves of N/2. After N accepted samples, the oldest sample no longer affects the output.
- R3: On acceptance, the oldest word of the front half is copied into the rear half's oldest slot before the new sample overwrites it. A sample then reaches the rear half after exactly N/2 further acceptances.
- R4: The write pointers wrap modulo N/2 and stay below N/2. Outputs remain correct over long runs with no pointer reinitialisation.
- R5: The accumulator is zero in the cycle after acceptance. Exactly N/2 multiply-accumulate steps then follow.
- R6: After each acceptance, in_ready is low for exactly N/2 cycles. A sample held valid during that time is taken exactly once, when ready returns.
- R7: out_valid is a one-cycle pulse that appears N/2+1 clock edges after the accepting edge. There is one pulse per accepted sample.
- R8: out_data is accumulator bits 30:15, clamped to 32767 or -32768 when the accumulator is outside that range.
- R9: The pre-adder is 17 bits wide. Sums of two full-scale samples of equal sign, such as -32768 + -32768, do not wrap.
- R10: Two cycles after reset is released, in_ready is 1, out_valid is 0 and out_data is 0. While in_valid is low, changes on in_data have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | 16 | Signed Q15 input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed Q15 filtered result |

## Verification
The embedded properties check several things on every cycle:
- the copy-then-write order in the delay line;
- the pointer range;
- the accumulator clear after acceptance;
- ready dropping on acceptance;
- the single-cycle width of the result strobe.

The numeric result cannot be judged cycle by cycle. This covers the folded sum, saturation at both rails, the 17-bit pre-add, and the ageing of samples out of the window. Only the bench's sweeps can show these, by comparing every output against an unfolded N-tap model. The sweeps are impulse, both full-scale steps, alternating full scale and a long pseudo-random stream. The exact ready-low length, the output latency and the one-for-one count of samples to results are measured by bench monitors.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sfir_state_e;
endpackage

// File: rtl/sfir_coef_rom.sv
module sfir_coef_rom #(
  parameter int CW = 16,
  parameter int HALF = 4,
  parameter int AW = 2,
  parameter logic [HALF*CW-1:0] COEFS = '0
) (
  input  logic [AW-1:0]        idx,
  output logic signed [CW-1:0] coef
);
  logic signed [CW-1:0] tbl [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tbl
    assign tbl[g] = COEFS[g*CW +: CW];
  end

  assign coef = tbl[idx];
endmodule

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
  parameter int DW = 16,
  parameter int HALF = 4,
  parameter int AW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [DW-1:0]        din,
  input  logic [AW-1:0]        tap,
  output logic signed [DW-1:0] rd_new,
  output logic signed [DW-1:0] rd_old
);
  logic [DW-1:0] mem_a [HALF];
  logic [DW-1:0] mem_b [HALF];
  logic [AW-1:0] wp_a, wp_b, wp_a_nxt, wp_b_nxt;
  logic [DW-1:0] oldest_a;
  logic [AW-1:0] idx_new, idx_old;

  assign oldest_a = mem_a[wp_a];

  // next pointer values, wrapping at HALF
  always_comb begin
    wp_a_nxt = wp_a;
    wp_b_nxt = wp_b;
    if (push) begin
      wp_a_nxt = (int'(wp_a) == HALF-1) ? '0 : wp_a + 1'b1;
      wp_b_nxt = (int'(wp_b) == HALF-1) ? '0 : wp_b + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_a <= '0;
      wp_b <= '0;
    end else if (push) begin
      wp_a <= wp_a_nxt;
      wp_b <= wp_b_nxt;
    end
  end

  // each word has its own write enable; the rear slot takes the displaced front word
  for (genvar g = 0; g < HALF; g++) begin : g_word
    logic we_a, we_b;
    assign we_a = push && (int'(wp_a) == g);
    assign we_b = push && (int'(wp_b) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_a[g] <= '0;
        mem_b[g] <= '0;
      end else begin
        if (we_a) mem_a[g] <= din;
        if (we_b) mem_b[g] <= oldest_a;
      end
    end
  end

  // tap t pairs x[n-t] (front) with x[n-(N-1)+t] (rear)
  always_comb begin
    int na, nb;
    na = int'(wp_a) - 1 - int'(tap);
    if (na < 0) na = na + HALF;
    nb = int'(wp_b) + int'(tap);
    if (nb >= HALF) nb = nb - HALF;
    idx_new = AW'(na);
    idx_old = AW'(nb);
  end

  assign rd_new = mem_a[idx_new];
  assign rd_old = mem_b[idx_old];

  a_r3_copy_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (mem_b[$past(wp_b)] == $past(oldest_a)) && (mem_a[$past(wp_a)] == $past(din)));
  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wp_a) < HALF) && (int'(wp_b) < HALF));
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (push && int'(wp_a) == HALF-1) |=> (wp_a == '0));
endmodule

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
#(
  parameter int HALF = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          step,
  output logic          last,
  output logic [AW-1:0] tap
);
  sfir_state_e state, state_nxt;
  logic [AW-1:0] tap_nxt;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = (state == ST_RUN);
  assign last     = step && (int'(tap) == HALF-1);

  always_comb begin
    state_nxt = state;
    tap_nxt   = tap;
    case (state)
      ST_IDLE: if (accept) begin
        state_nxt = ST_RUN;
        tap_nxt   = '0;
      end
      ST_RUN: begin
        if (last) state_nxt = ST_IDLE;
        else      tap_nxt   = tap + 1'b1;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tap   <= '0;
    end else begin
      state <= state_nxt;
      tap   <= tap_nxt;
    end
  end

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && tap == '0));
  a_r5_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> in_ready);
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int ACCW = 40,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic                 last,
  input  logic signed [DW-1:0] smp_new,
  input  logic signed [DW-1:0] smp_old,
  input  logic signed [CW-1:0] coef,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int PW = DW + 1;
  localparam int MW = PW + CW;
  localparam logic signed [ACCW-1:0] SMAX = ACCW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] SMIN = -SMAX - 1;

  logic signed [PW-1:0]   pre;
  logic signed [MW-1:0]   prod;
  logic signed [ACCW-1:0] acc, acc_nxt, scaled;
  logic signed [DW-1:0]   sat_val;
  logic                   acc_en;

  assign pre  = PW'(smp_new) + PW'(smp_old);
  assign prod = MW'(pre) * MW'(coef);

  assign acc_en = clr || step;

  always_comb begin
    acc_nxt = acc;
    if (clr)       acc_nxt = '0;
    else if (step) acc_nxt = acc + ACCW'(prod);
  end

  always_comb begin
    scaled = acc_nxt >>> FRAC;
    if (scaled > SMAX)      sat_val = SMAX[DW-1:0];
    else if (scaled < SMIN) sat_val = SMIN[DW-1:0];
    else                    sat_val = scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= last;
      if (last) out_data <= sat_val;
    end
  end

  a_r5_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r8_rail_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (acc_nxt >>> FRAC) > SMAX) |=> (out_data == SMAX[DW-1:0]));
  a_r8_rail_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (acc_nxt >>> FRAC) < SMIN) |=> (out_data == SMIN[DW-1:0]));
endmodule

// File: rtl/sym_fir_engine.sv
module sym_fir_engine #(
  parameter int N = 8,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int ACCW = 40,
  parameter int FRAC = 15,
  parameter logic [(N/2)*CW-1:0] COEFS = 64'h4E20_2EE0_E000_4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int HALF = N / 2;
  localparam int AW = (HALF > 1) ? $clog2(HALF) : 1;

  logic rst_meta, rst_sync;
  logic accept, step, last;
  logic [AW-1:0] tap;
  logic signed [DW-1:0] smp_new, smp_old, out_s;
  logic signed [CW-1:0] coef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sfir_ctrl #(.HALF(HALF), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .step(step), .last(last), .tap(tap)
  );

  sfir_delay_line #(.DW(DW), .HALF(HALF), .AW(AW)) u_dly (
    .clk(clk), .rst_n(rst_sync), .push(accept), .din(in_data), .tap(tap),
    .rd_new(smp_new), .rd_old(smp_old)
  );

  sfir_coef_rom #(.CW(CW), .HALF(HALF), .AW(AW), .COEFS(COEFS)) u_rom (
    .idx(tap), .coef(coef)
  );

  sfir_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_n(rst_sync), .clr(accept), .step(step), .last(last),
    .smp_new(smp_new), .smp_old(smp_old), .coef(coef),
    .out_valid(out_valid), .out_data(out_s)
  );

  assign out_data = out_s;
endmodule

// File: tb/sym_fir_engine_test.sv
module sym_fir_engine_test;
  localparam int N = 8;
  localparam int HALF = N / 2;
  localparam logic [HALF*16-1:0] COEFS = 64'h4E20_2EE0_E000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int hist [N];
  int expq [$];
  int accq [$];
  int cyc = 0;
  int n_acc = 0;
  int n_out = 0;
  int low_run = 0;
  logic prev_ov = 1'b0;
  logic mon_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sym_fir_engine #(.N(N), .COEFS(COEFS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int hcoef(int k);
    int i;
    i = (k < HALF) ? k : N - 1 - k;
    return int'($signed(COEFS[i*16 +: 16]));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // unfolded N-tap reference, built on each acceptance (R1,R2,R3,R8)
  always @(posedge clk) begin
    if (mon_on && in_valid && in_ready) begin
      longint s, q;
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(in_data));
      s = 0;
      for (int k = 0; k < N; k++) s += longint'(hcoef(k)) * longint'(hist[k]);
      q = s >>> 15;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      expq.push_back(int'(q));
      accq.push_back(cyc);
      n_acc++;
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        int e, a;
        n_out++;
        e = (expq.size() > 0) ? expq.pop_front() : 0;
        a = (accq.size() > 0) ? accq.pop_front() : 0;
        chk(int'($signed(out_data)) == e, "R1 R2 R3 R4 R8 R9 output", int'($signed(out_data)), e);
        chk(cyc - a == HALF + 1, "R7 latency", cyc - a, HALF + 1);
      end
      chk(!(out_valid && prev_ov), "R7 pulse width", int'(out_valid), 0);
      if (!in_ready) low_run++;
      else if (low_run != 0) begin
        chk(low_run == HALF, "R6 R5 ready-low length", low_run, HALF);
        low_run = 0;
      end
    end
    prev_ov = out_valid;
  end

  // hold valid until taken; valid stays high into the next sample when back-to-back
  task automatic put(int v, bit keep);
    in_valid = 1'b1;
    in_data  = 16'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (!keep) begin
      in_valid = 1'b0;
      in_data  = 16'h5A5A ^ 16'(cyc);   // R10: data moves while valid low
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_data = 16'(cyc * 977);
      @(negedge clk);
    end
  endtask

  task automatic drain;
    while (expq.size() > 0) @(negedge clk);
    idle(2);
  endtask

  initial begin
    for (int k = 0; k < N; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    chk(out_data == 16'd0, "R10 reset data", int'(out_data), 0);
    mon_on = 1'b1;

    // impulse: walks each coefficient through the window (R1,R2,R3)
    put(32767, 0); idle(1);
    for (int i = 0; i < N + 2; i++) begin put(0, 0); idle(i % 3); end
    drain;
    // negative impulse
    put(-32768, 0);
    for (int i = 0; i < N + 1; i++) put(0, 0);
    drain;
    // positive full-scale step: saturates high (R8)
    for (int i = 0; i < N + 2; i++) put(32767, 0);
    drain;
    // negative full-scale step: pre-add of two -32768 (R9), saturates low (R8)
    for (int i = 0; i < N + 2; i++) put(-32768, 0);
    drain;
    // alternating full scale
    for (int i = 0; i < 2 * N; i++) put((i % 2) ? 32767 : -32768, 0);
    drain;
    // small ramp, back-to-back with valid held through busy cycles (R6)
    for (int i = 0; i < 3 * N; i++) put(i * 411 - 4000, 1);
    in_valid = 1'b0;
    drain;
    // long pseudo-random stream, mixed gaps, pointers wrap many times (R4)
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      put(int'($signed(lfsr)), (i % 5) != 0);
      if (i % 7 == 0) begin in_valid = 1'b0; idle(i % 4); end
    end
    in_valid = 1'b0;
    drain;
    // one result per accepted sample (R7)
    chk(n_out == n_acc, "R7 result count", n_out, n_acc);
    summary;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary;
    $finish;
  end
endmodule